// File: doc/BRIEF.md
# Standby Entry and Wake Controller

This block puts a small processor subsystem into a deep power-saving state and brings it back out. A sleep strobe from the core enters standby only when software has set the standby-enable control bit. In standby the core clock, the peripheral clocks and the external clock output are all gated off. Two status pins tell the board whether the subsystem is in standby.

Five wake sources can end standby: a non-maskable interrupt, a rising edge on the external interrupt line, the real-time-clock interrupt, the timer interrupt and the pin-change interrupt. No interrupt mask in the core affects them. After a wake the clocks stay gated while an 8-bit settling counter advances on a divided clock. The clocks return only when the counter wraps. The first wake source is latched as a one-hot cause code for the interrupt logic.

If software leaves the standby-enable bit set after waking, the counter keeps running and the block drops back into standby by itself. While that bit is set, manual reset requests are refused. A power-on reset returns everything to the running state at once.

Top module: `stby_ctrl`

## Requirements
- R1: A sleep strobe enters standby on the next clock edge only if the standby-enable bit is 1. When the bit is 0, the strobe has no effect and the clocks keep running.
- R2: In standby and while settling, the core, peripheral and external clock enables are all 0. In every other state all three are 1.
- R3: Status pin 0 is 1 and status pin 1 is 0 in standby and while settling. Both pins are 0 while running.
- R4: In standby, a high NMI, RTC, timer or pin-change request starts a wake on the next edge. The external interrupt line wakes only on a low-to-high transition, so a level already high at entry does not wake.
- R5: Settling starts with the counter at 0. The counter advances once every 2^(cks+1) cycles, where cks is the 3-bit clock-select field. The clocks return on the edge 256*2^(cks+1) cycles after the wake edge.
- R6: If the standby-enable bit is still 1 after the clocks return, the block re-enters standby when the counter reaches 0x80. This happens 128*2^(cks+1) cycles after the clocks return.
- R7: Clearing the standby-enable bit after wake stops the counter, and the block stays running with no re-entry.
- R8: A manual reset request gives a one-cycle pulse on mrst_out one edge later, but only while the standby-enable bit is 0. While the bit is 1, mrst_out stays 0.
- R9: The wake cause is one-hot, with bit 4 NMI, bit 3 external interrupt, bit 2 RTC, bit 1 timer and bit 0 pin-change. When several sources are requested together, the highest bit wins.
- R10: A power-on reset goes straight to the running state with no settling delay. It clears the standby-enable bit, the clock-select field and the wake cause.
- R11: Wake requests that arrive while running or settling leave the wake cause and the state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on slow clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| sleep_req | input | 1 | One-cycle sleep strobe from the core |
| cfg_we | input | 1 | Write strobe for the control fields |
| cfg_stby_en | input | 1 | Standby-enable value to write |
| cfg_cks | input | 3 | Settling clock-select value to write |
| mrst_req | input | 1 | Manual reset request |
| wake_nmi | input | 1 | Non-maskable wake request |
| wake_irq | input | 1 | External interrupt line (edge detected) |
| wake_rtc | input | 1 | Real-time-clock wake request |
| wake_tmr | input | 1 | Timer wake request |
| wake_pin | input | 1 | Pin-change wake request |
| cpu_clk_en | output | 1 | Core clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| ckout_en | output | 1 | External clock output enable |
| stat0 | output | 1 | Status pin 0 |
| stat1 | output | 1 | Status pin 1 |
| wake_cause | output | 5 | Latched one-hot wake cause |
| mrst_out | output | 1 | Accepted manual reset pulse |

## Verification
All state-derived outputs change on the first edge after the stimulus. The bench drives inputs on the falling edge and samples one falling edge later. For the settling and re-entry windows, it waits exactly one cycle short of the computed edge (255*D+... counted from the wake edge, with D = 2^(cks+1)) and confirms the old value, then advances one cycle and confirms the new value. The wake cause is latched on the wake edge, and the manual reset pulse appears one edge after the request; both are sampled at that point.

// File: rtl/stby_pkg.sv
package stby_pkg;

    parameter int CNT_W = 8;
    parameter int CKS_W = 3;
    parameter int NSRC  = 5;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_STBY   = 2'd1,
        ST_SETTLE = 2'd2,
        ST_WDRUN  = 2'd3
    } pwr_st_e;

    // field order sets priority: first member is the MSB and wins
    typedef struct packed {
        logic nmi;
        logic irq;
        logic rtc;
        logic tmr;
        logic pin;
    } wake_vec_t;

    typedef struct packed {
        logic cpu;
        logic per;
        logic ckout;
    } clk_en_t;

    function automatic logic [NSRC-1:0] pick_first(input logic [NSRC-1:0] r);
        logic [NSRC-1:0] g;
        g = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (r[i] && (g == '0)) g[i] = 1'b1;
        end
        return g;
    endfunction

    function automatic clk_en_t clocks_for(input pwr_st_e s);
        clk_en_t c;
        c = (s == ST_RUN || s == ST_WDRUN) ? 3'b111 : 3'b000;
        return c;
    endfunction

endpackage

// File: rtl/stby_wake_src.sv
module stby_wake_src
    import stby_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            nmi,
    input  logic            irq,
    input  logic            rtc,
    input  logic            tmr,
    input  logic            pin,
    output logic [NSRC-1:0] grant,
    output logic            any
);
    logic      irq_q;
    wake_vec_t req;

    always_ff @(posedge clk) begin
        irq_q <= irq;
    end

    always_comb begin
        req.nmi = nmi;
        req.irq = irq & ~irq_q;
        req.rtc = rtc;
        req.tmr = tmr;
        req.pin = pin;
        grant   = pick_first(req);
        any     = |req;
    end

    AST_IRQ_LEVEL_NO_WAKE: assert property (@(posedge clk) disable iff (rst)
        (irq && $past(irq)) |-> !grant[3]);  // R4

endmodule

// File: rtl/stby_settle_cnt.sv
module stby_settle_cnt
    import stby_pkg::*;
#(
    parameter int W  = CNT_W,
    parameter int SW = CKS_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [SW-1:0] cks,
    output logic [W-1:0]  cnt,
    output logic          tick
);
    localparam int PRE_W = 1 << SW;

    logic [PRE_W-1:0] presc;
    logic [PRE_W:0]   lim;

    always_comb begin
        lim  = ({{PRE_W{1'b0}}, 1'b1} << ({1'b0, cks} + 1'b1)) - 1'b1;
        tick = run && (presc == lim[PRE_W-1:0]);
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            presc <= '0;
            cnt   <= '0;
        end else if (tick) begin
            presc <= '0;
            cnt   <= cnt + 1'b1;
        end else begin
            presc <= presc + 1'b1;
        end
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        tick |=> cnt == W'($past(cnt) + 1'b1));  // R5

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (run && !tick) |=> cnt == $past(cnt));  // R5

endmodule

// File: rtl/stby_ctrl.sv
module stby_ctrl
    import stby_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sleep_req,
    input  logic             cfg_we,
    input  logic             cfg_stby_en,
    input  logic [CKS_W-1:0] cfg_cks,
    input  logic             mrst_req,
    input  logic             wake_nmi,
    input  logic             wake_irq,
    input  logic             wake_rtc,
    input  logic             wake_tmr,
    input  logic             wake_pin,
    output logic             cpu_clk_en,
    output logic             per_clk_en,
    output logic             ckout_en,
    output logic             stat0,
    output logic             stat1,
    output logic [NSRC-1:0]  wake_cause,
    output logic             mrst_out
);
    localparam logic [CNT_W-1:0] CNT_TOP   = '1;
    localparam logic [CNT_W-1:0] REENTRY_M1 = CNT_W'((1 << (CNT_W - 1)) - 1);

    pwr_st_e          st;
    logic             stby_en;
    logic [CKS_W-1:0] cks;
    logic [NSRC-1:0]  w_grant;
    logic             w_any;
    logic [CNT_W-1:0] cnt;
    logic             tick;
    logic             cnt_run;
    clk_en_t          ce;

    stby_wake_src u_src (
        .clk   (clk),
        .rst   (rst),
        .nmi   (wake_nmi),
        .irq   (wake_irq),
        .rtc   (wake_rtc),
        .tmr   (wake_tmr),
        .pin   (wake_pin),
        .grant (w_grant),
        .any   (w_any)
    );

    assign cnt_run = (st == ST_SETTLE) || (st == ST_WDRUN);

    stby_settle_cnt #(.W(CNT_W), .SW(CKS_W)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .run  (cnt_run),
        .cks  (cks),
        .cnt  (cnt),
        .tick (tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_RUN;
            stby_en    <= 1'b0;
            cks        <= '0;
            wake_cause <= '0;
            mrst_out   <= 1'b0;
        end else begin
            if (cfg_we) begin
                stby_en <= cfg_stby_en;
                cks     <= cfg_cks;
            end
            mrst_out <= mrst_req & ~stby_en;
            unique case (st)
                ST_RUN: begin
                    if (sleep_req && stby_en) st <= ST_STBY;
                end
                ST_STBY: begin
                    if (w_any) begin
                        st         <= ST_SETTLE;
                        wake_cause <= w_grant;
                    end
                end
                ST_SETTLE: begin
                    if (tick && cnt == CNT_TOP) st <= ST_WDRUN;
                end
                ST_WDRUN: begin
                    if (sleep_req && stby_en)             st <= ST_STBY;
                    else if (!stby_en)                    st <= ST_RUN;
                    else if (tick && cnt == REENTRY_M1)   st <= ST_STBY;
                end
                default: st <= ST_RUN;
            endcase
        end
    end

    always_comb begin
        ce         = clocks_for(st);
        cpu_clk_en = ce.cpu;
        per_clk_en = ce.per;
        ckout_en   = ce.ckout;
        stat0      = (st == ST_STBY) || (st == ST_SETTLE);
        stat1      = 1'b0;
    end

    AST_NO_ENTRY_WO_EN: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RUN && !stby_en) |=> st == ST_RUN);  // R1

    AST_STBY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (st == ST_STBY && !w_any) |=> st == ST_STBY);  // R4

    AST_SETTLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SETTLE && !(tick && cnt == CNT_TOP)) |=> st == ST_SETTLE);  // R5

    AST_CAUSE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wake_cause));  // R9

    AST_CAUSE_STABLE: assert property (@(posedge clk) disable iff (rst)
        (st != ST_STBY) |=> $stable(wake_cause));  // R11

    AST_MRST_BLOCK: assert property (@(posedge clk) disable iff (rst)
        stby_en |=> !mrst_out);  // R8

    AST_CLOCKS_BACK: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SETTLE && tick && cnt == CNT_TOP) |=> cpu_clk_en);  // R2

endmodule

// File: tb/sim_stby_ctrl.sv
`timescale 1ns/1ps
module sim_stby_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sleep_req = 1'b0;
    logic       cfg_we = 1'b0;
    logic       cfg_stby_en = 1'b0;
    logic [2:0] cfg_cks = 3'd0;
    logic       mrst_req = 1'b0;
    logic       wake_nmi = 1'b0;
    logic       wake_irq = 1'b0;
    logic       wake_rtc = 1'b0;
    logic       wake_tmr = 1'b0;
    logic       wake_pin = 1'b0;
    logic       cpu_clk_en, per_clk_en, ckout_en, stat0, stat1, mrst_out;
    logic [4:0] wake_cause;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    stby_ctrl u0 (
        .clk(clk), .rst(rst), .sleep_req(sleep_req), .cfg_we(cfg_we),
        .cfg_stby_en(cfg_stby_en), .cfg_cks(cfg_cks), .mrst_req(mrst_req),
        .wake_nmi(wake_nmi), .wake_irq(wake_irq), .wake_rtc(wake_rtc),
        .wake_tmr(wake_tmr), .wake_pin(wake_pin), .cpu_clk_en(cpu_clk_en),
        .per_clk_en(per_clk_en), .ckout_en(ckout_en), .stat0(stat0),
        .stat1(stat1), .wake_cause(wake_cause), .mrst_out(mrst_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // clocks enables and status packed: {cpu,per,ck,stat0,stat1}
    function automatic logic [31:0] outs();
        return {27'd0, cpu_clk_en, per_clk_en, ckout_en, stat0, stat1};
    endfunction

    localparam logic [31:0] RUNV  = 32'b11100;
    localparam logic [31:0] STBYV = 32'b00010;

    task automatic cfg(input logic en, input logic [2:0] k);
        cfg_we = 1'b1; cfg_stby_en = en; cfg_cks = k;
        cyc(1);
        cfg_we = 1'b0;
    endtask

    task automatic sleep_pulse();
        sleep_req = 1'b1;
        cyc(1);
        sleep_req = 1'b0;
    endtask

    task automatic t_reset();
        chk("R10 reset outputs", outs(), RUNV);
        chk("R10 reset cause", wake_cause, 0);
    endtask

    task automatic t_sleep_no_en();
        sleep_pulse();
        chk("R1 no entry when disabled", outs(), RUNV);
        cyc(3);
        chk("R1 still running", outs(), RUNV);
    endtask

    task automatic t_enter(input logic [2:0] k);
        cfg(1'b1, k);
        sleep_pulse();
        chk("R1 R2 R3 standby entered", outs(), STBYV);
    endtask

    // NMI wake with cks=0, settling then automatic re-entry
    task automatic t_nmi_reentry();
        t_enter(3'd0);
        cyc(4);
        chk("R4 no wake without request", outs(), STBYV);
        wake_nmi = 1'b1;
        cyc(1);
        wake_nmi = 1'b0;
        chk("R2 R3 settling keeps clocks off", outs(), STBYV);
        cyc(511);
        chk("R5 still settling at 511", outs(), STBYV);
        cyc(1);
        chk("R5 clocks back at 512", outs(), RUNV);
        chk("R9 cause NMI", wake_cause, 5'b10000);
        cyc(255);
        chk("R6 running at 767", outs(), RUNV);
        cyc(1);
        chk("R6 re-entered at 768", outs(), STBYV);
    endtask

    task automatic t_clear_en();
        wake_pin = 1'b1;
        cyc(1);
        wake_pin = 1'b0;
        cfg(1'b0, 3'd0);
        cyc(520);
        chk("R7 awake after settle", outs(), RUNV);
        chk("R9 cause pin", wake_cause, 5'b00001);
        cyc(400);
        chk("R7 no re-entry once cleared", outs(), RUNV);
    endtask

    task automatic t_mrst();
        mrst_req = 1'b1;
        cyc(1);
        mrst_req = 1'b0;
        chk("R8 accepted when disabled", mrst_out, 1);
        cyc(1);
        chk("R8 one cycle pulse", mrst_out, 0);
        cfg(1'b1, 3'd0);
        mrst_req = 1'b1;
        cyc(1);
        chk("R8 blocked when enabled", mrst_out, 0);
        cyc(1);
        mrst_req = 1'b0;
        chk("R8 still blocked", mrst_out, 0);
        cfg(1'b0, 3'd0);
    endtask

    task automatic t_irq_edge();
        wake_irq = 1'b1;
        cyc(2);
        t_enter(3'd0);
        cyc(4);
        chk("R4 held irq level does not wake", outs(), STBYV);
        wake_irq = 1'b0;
        cyc(1);
        chk("R4 falling irq does not wake", outs(), STBYV);
        wake_irq = 1'b1;
        cyc(1);
        wake_irq = 1'b0;
        cfg(1'b0, 3'd0);
        cyc(520);
        chk("R4 irq edge woke", outs(), RUNV);
        chk("R9 cause irq", wake_cause, 5'b01000);
    endtask

    task automatic t_priority();
        t_enter(3'd0);
        wake_rtc = 1'b1; wake_tmr = 1'b1; wake_pin = 1'b1;
        cyc(1);
        wake_rtc = 1'b0; wake_tmr = 1'b0; wake_pin = 1'b0;
        chk("R9 rtc beats tmr and pin", wake_cause, 5'b00100);
        wake_nmi = 1'b1;
        cyc(1);
        wake_nmi = 1'b0;
        chk("R11 wake during settle ignored", wake_cause, 5'b00100);
        cfg(1'b0, 3'd0);
        cyc(520);
        chk("R11 running after settle", outs(), RUNV);
        wake_tmr = 1'b1;
        cyc(1);
        wake_tmr = 1'b0;
        cyc(1);
        chk("R11 run wake keeps cause", wake_cause, 5'b00100);
        chk("R11 run wake keeps state", outs(), RUNV);
    endtask

    task automatic t_cks1();
        t_enter(3'd1);
        wake_tmr = 1'b1;
        cyc(1);
        wake_tmr = 1'b0;
        cyc(1023);
        chk("R5 cks1 settling at 1023", outs(), STBYV);
        cyc(1);
        chk("R5 cks1 clocks back at 1024", outs(), RUNV);
        chk("R9 cause timer", wake_cause, 5'b00010);
        cfg(1'b0, 3'd0);
    endtask

    task automatic t_por_stby();
        t_enter(3'd2);
        rst = 1'b1;
        cyc(2);
        rst = 1'b0;
        chk("R10 reset leaves standby at once", outs(), RUNV);
        chk("R10 reset clears cause", wake_cause, 0);
        sleep_pulse();
        chk("R10 reset cleared enable", outs(), RUNV);
    endtask

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(1);
        t_reset();
        t_sleep_no_en();
        t_nmi_reentry();
        t_clear_en();
        t_mrst();
        t_irq_edge();
        t_priority();
        t_cks1();
        t_por_stby();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule